// File: doc/BRIEF.md
# Controller Quiesce Mailbox Responder

This block models the responder side of a small command mailbox. A host reaches it through two byte registers: a pointer at offset 0 and a data port at offset 1. The pointer selects one of a bank of mailbox bytes, and the data port reads or writes the byte it selects. The host uses the mailbox to ask an embedded controller to stop using a shared SMBus segment, or to start using it again.

A request takes three steps. The host clears the completion byte at index 0x82. It places a command in index 0x83, where 0xB4 means "go quiet" and 0xB5 means "resume". It then writes the go value 0x96 to index 0x80. The responder accepts the request only if the command is a valid one. After a delay set by a parameter, it writes 0xFA into index 0x82 and updates the `quiesced` output on the same clock edge. The host polls index 0x82 until it reads 0xFA. A request with a wrong go value or an unknown command is never answered, so the host's polling runs out of time. A second go value written while a request is still pending is dropped.

Host access is a plain register strobe with no back-pressure. A write takes effect at the clock edge where `host_wr` is sampled high. A read returns its byte on `host_rdata` one cycle after `host_rd` is sampled, and `host_rdata` holds that byte until the next read.

Top module: `mbx_quiesce_responder`

## Requirements
- R1: After reset, the pointer and every mailbox byte read as 0x00, `host_rdata` is 0x00 and `quiesced` is 0.
- R2: A write at offset 0 loads the pointer. A read at offset 0 returns the pointer. A write at offset 1 stores into the byte the pointer selects, and a read at offset 1 returns that byte. Read data appears one cycle after the read strobe.
- R3: Only indices 0x80 to 0x8F (with default parameters) hold mailbox bytes. A data write to any other index is dropped, and a data read of any other index returns 0x00.
- R4: When 0x96 is written to index 0x80 while index 0x83 holds 0xB4 and no request is pending, index 0x82 becomes 0xFA and `quiesced` becomes 1. Both happen exactly DONE_DELAY cycles after the edge that took the go write.
- R5: The same sequence with command 0xB5 writes 0xFA and sets `quiesced` to 0 at the same edge.
- R6: A write of any value other than 0x96 to index 0x80 leaves index 0x82 and `quiesced` unchanged.
- R7: A go write while index 0x83 holds any value other than 0xB4 or 0xB5 leaves index 0x82 and `quiesced` unchanged.
- R8: While a request is pending, further go writes are dropped and are not queued. The command is latched at the go edge, so rewriting index 0x83 before completion does not change the outcome or its timing.
- R9: `quiesced` changes only on an edge where index 0x82 is written with 0xFA.
- R10: When a host data write to index 0x82 falls on the completion edge, the completion value 0xFA wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for one cycle |
| host_rd | input | 1 | Read strobe for one cycle |
| host_sel | input | 1 | Register offset: 0 is the pointer, 1 is the data port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid one cycle after `host_rd` |
| quiesced | output | 1 | 1 while the controller has released the shared bus |

## Verification
The checker tests on every cycle that `quiesced` moves only together with the 0xFA completion byte and only at the end of a pending request. It also checks that a bad go value disturbs neither the completion byte nor `quiesced`, and that pointer reads and out-of-range data reads return the right values. The exact DONE_DELAY timing, the latching of the command at the go edge, the dropping of a second go write, and the precedence of completion over a host write that lands on the same edge can only be shown by the bench's timed scenarios. The bench mixes those directed cases with seeded random requests and compares the results against a small reference model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] IDX_TRIGGER = 8'h80;
  localparam logic [7:0] IDX_STATUS  = 8'h82;
  localparam logic [7:0] IDX_CMD     = 8'h83;
  localparam logic [7:0] GO_CODE     = 8'h96;
  localparam logic [7:0] CMD_SLEEP   = 8'hB4;
  localparam logic [7:0] CMD_WAKE    = 8'hB5;
  localparam logic [7:0] DONE_CODE   = 8'hFA;

  typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;
endpackage

// File: rtl/mbx_regwin.sv
module mbx_regwin
  import mbx_pkg::*;
#(
  parameter logic [7:0] SLOT_BASE  = 8'h80,
  parameter int         SLOT_COUNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  input  logic       done_post,
  output logic [7:0] host_rdata,
  output logic [7:0] index_q,
  output logic       trig_fire,
  output logic [7:0] cmd_byte,
  output logic [7:0] status_byte
);
  localparam int         SLOT_AW    = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1;
  localparam logic [8:0] SLOT_END   = {1'b0, SLOT_BASE} + 9'(SLOT_COUNT);
  localparam logic [SLOT_AW-1:0] OFS_STATUS = SLOT_AW'(IDX_STATUS - SLOT_BASE);
  localparam logic [SLOT_AW-1:0] OFS_CMD    = SLOT_AW'(IDX_CMD - SLOT_BASE);

  logic [7:0]         slot_q [SLOT_COUNT];
  logic               in_range;
  logic [SLOT_AW-1:0] slot_ofs;
  logic [SLOT_COUNT-1:0] slot_hit;

  assign in_range = ({1'b0, index_q} >= {1'b0, SLOT_BASE}) && ({1'b0, index_q} < SLOT_END);
  assign slot_ofs = SLOT_AW'(index_q - SLOT_BASE);

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_hit
    assign slot_hit[i] = in_range && (slot_ofs == SLOT_AW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= 8'h00;
      host_rdata <= 8'h00;
      for (int i = 0; i < SLOT_COUNT; i++) slot_q[i] <= 8'h00;
    end else begin
      if (host_wr && !host_sel) index_q <= host_wdata;
      for (int i = 0; i < SLOT_COUNT; i++) begin
        if (host_wr && host_sel && slot_hit[i]) slot_q[i] <= host_wdata;
      end
      // completion posting takes precedence over a host write (R10)
      if (done_post) slot_q[OFS_STATUS] <= DONE_CODE;
      if (host_rd) begin
        if (!host_sel)     host_rdata <= index_q;
        else if (in_range) host_rdata <= slot_q[slot_ofs];
        else               host_rdata <= 8'h00;
      end
    end
  end

  assign trig_fire   = host_wr && host_sel && (index_q == IDX_TRIGGER);
  assign cmd_byte    = slot_q[OFS_CMD];
  assign status_byte = slot_q[OFS_STATUS];
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int DONE_DELAY = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_fire,
  input  logic [7:0] trig_value,
  input  logic [7:0] cmd_byte,
  output logic       done_post,
  output logic       busy,
  output logic       quiesced
);
  localparam int CW = (DONE_DELAY > 1) ? $clog2(DONE_DELAY + 1) : 1;

  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          want_sleep_q;
  logic          cmd_known;
  logic          accept;

  assign cmd_known = (cmd_byte == CMD_SLEEP) || (cmd_byte == CMD_WAKE);
  assign accept    = trig_fire && (trig_value == GO_CODE) && cmd_known && (state_q == ENG_IDLE);
  assign done_post = (state_q == ENG_WAIT) && (cnt_q == '0);
  assign busy      = (state_q == ENG_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ENG_IDLE;
      cnt_q        <= '0;
      want_sleep_q <= 1'b0;
      quiesced     <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (accept) begin
            state_q      <= ENG_WAIT;
            cnt_q        <= CW'(DONE_DELAY - 1);
            want_sleep_q <= (cmd_byte == CMD_SLEEP);
          end
        end
        ENG_WAIT: begin
          if (cnt_q == '0) begin
            state_q  <= ENG_IDLE;
            quiesced <= want_sleep_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_quiesce_responder.sv
module mbx_quiesce_responder
  import mbx_pkg::*;
#(
  parameter logic [7:0] SLOT_BASE  = 8'h80,
  parameter int         SLOT_COUNT = 16,
  parameter int         DONE_DELAY = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       quiesced
);
  logic [7:0] index_q;
  logic [7:0] cmd_byte;
  logic [7:0] status_byte;
  logic       trig_fire;
  logic       done_post;
  logic       busy;

  mbx_regwin #(.SLOT_BASE(SLOT_BASE), .SLOT_COUNT(SLOT_COUNT)) u_regwin (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .done_post   (done_post),
    .host_rdata  (host_rdata),
    .index_q     (index_q),
    .trig_fire   (trig_fire),
    .cmd_byte    (cmd_byte),
    .status_byte (status_byte)
  );

  mbx_engine #(.DONE_DELAY(DONE_DELAY)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_fire  (trig_fire),
    .trig_value (host_wdata),
    .cmd_byte   (cmd_byte),
    .done_post  (done_post),
    .busy       (busy),
    .quiesced   (quiesced)
  );
endmodule

// File: rtl/mbx_quiesce_checker.sv
module mbx_quiesce_checker
  import mbx_pkg::*;
#(
  parameter logic [7:0] SLOT_BASE  = 8'h80,
  parameter int         SLOT_COUNT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       quiesced,
  input logic [7:0] index_q,
  input logic [7:0] status_byte,
  input logic       busy
);
  localparam logic [8:0] SLOT_END = {1'b0, SLOT_BASE} + 9'(SLOT_COUNT);
  logic outside;
  assign outside = ({1'b0, index_q} < {1'b0, SLOT_BASE}) || ({1'b0, index_q} >= SLOT_END);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!quiesced && host_rdata == 8'h00));

  assert_pointer_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel) |=> host_rdata == $past(index_q));

  assert_outside_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && outside) |=> host_rdata == 8'h00);

  assert_rise_ends_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiesced) |-> $past(busy));

  assert_bad_go_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && index_q == IDX_TRIGGER && host_wdata != GO_CODE && !busy)
      |=> ($stable(quiesced) && $stable(status_byte)));

  assert_quiesce_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiesced != $past(quiesced)) |-> (status_byte == DONE_CODE && $past(busy)));
endmodule

bind mbx_quiesce_responder mbx_quiesce_checker #(.SLOT_BASE(SLOT_BASE), .SLOT_COUNT(SLOT_COUNT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_sel    (host_sel),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .quiesced    (quiesced),
  .index_q     (index_q),
  .status_byte (status_byte),
  .busy        (busy)
);

// File: tb/sim_mbx_quiesce_responder.sv
`timescale 1ns/1ps
module sim_mbx_quiesce_responder;
  localparam int D = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       quiesced;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic exp_q = 1'b0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbx_quiesce_responder #(.DONE_DELAY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .quiesced(quiesced)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] v);
    wr_reg(1'b0, 8'h82);
    rd_reg(1'b1, v);
  endtask

  task automatic send_req(input logic [7:0] cmd, input logic [7:0] go, output int e);
    wr_reg(1'b0, 8'h82); wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h83); wr_reg(1'b1, cmd);
    wr_reg(1'b0, 8'h80); wr_reg(1'b1, go);
    e = cyc;
  endtask

  function automatic logic req_valid(input logic [7:0] cmd, input logic [7:0] go);
    return (go == 8'h96) && (cmd == 8'hB4 || cmd == 8'hB5);
  endfunction

  task automatic run_case(input string req, input logic [7:0] cmd, input logic [7:0] go);
    int e;
    logic [7:0] v;
    logic ok;
    logic nq;
    ok = req_valid(cmd, go);
    nq = ok ? (cmd == 8'hB4) : exp_q;
    send_req(cmd, go, e);
    if (ok && nq != exp_q) begin
      wait_until(e + D - 1);
      check8({req, " quiesced before delay"}, {7'd0, quiesced}, {7'd0, exp_q});
    end
    wait_until(e + D);
    check8({req, " quiesced at delay"}, {7'd0, quiesced}, {7'd0, nq});
    wait_until(e + D + 2);
    read_status(v);
    check8({req, " completion byte"}, v, ok ? 8'hFA : 8'h00);
    exp_q = nq;
  endtask

  initial begin
    logic [7:0] v;
    int e;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check8("R1 quiesced", {7'd0, quiesced}, 8'h00);
    rd_reg(1'b0, v); check8("R1 pointer", v, 8'h00);
    read_status(v);  check8("R1 status slot", v, 8'h00);

    // R2: pointer and data access
    wr_reg(1'b0, 8'h85); wr_reg(1'b1, 8'hA5);
    rd_reg(1'b1, v); check8("R2 data readback", v, 8'hA5);
    rd_reg(1'b0, v); check8("R2 pointer readback", v, 8'h85);

    // R3: indices outside the mailbox
    wr_reg(1'b0, 8'h7F); wr_reg(1'b1, 8'h3C);
    rd_reg(1'b1, v); check8("R3 below range", v, 8'h00);
    wr_reg(1'b0, 8'h90); wr_reg(1'b1, 8'h5A);
    rd_reg(1'b1, v); check8("R3 above range", v, 8'h00);
    wr_reg(1'b0, 8'h85);
    rd_reg(1'b1, v); check8("R3 in-range slot untouched", v, 8'hA5);

    run_case("R4 sleep", 8'hB4, 8'h96);
    run_case("R5 wake", 8'hB5, 8'h96);
    run_case("R4 sleep again", 8'hB4, 8'h96);
    run_case("R6 bad go value", 8'hB5, 8'h69);
    run_case("R7 unknown command", 8'h42, 8'h96);
    run_case("R5 wake again", 8'hB5, 8'h96);

    // R8: second go while pending, command rewritten
    send_req(8'hB4, 8'h96, e);
    wr_reg(1'b0, 8'h83); wr_reg(1'b1, 8'hB5);
    wr_reg(1'b0, 8'h80); wr_reg(1'b1, 8'h96);
    wait_until(e + D - 1);
    check8("R8 not done early", {7'd0, quiesced}, 8'h00);
    wait_until(e + D);
    check8("R8 first command wins", {7'd0, quiesced}, 8'h01);
    wait_until(e + 2 * D + 5);
    check8("R8 second go not queued", {7'd0, quiesced}, 8'h01);
    read_status(v); check8("R8 completion byte", v, 8'hFA);
    exp_q = 1'b1;

    // R10: host write of the status slot on the completion edge
    send_req(8'hB5, 8'h96, e);
    wr_reg(1'b0, 8'h82);
    wait_until(e + D - 1);
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = 8'h11;
    @(negedge clk);
    host_wr = 1'b0;
    check8("R10 wake applied", {7'd0, quiesced}, 8'h00);
    rd_reg(1'b1, v); check8("R10 completion wins", v, 8'hFA);
    exp_q = 1'b0;

    // R9 with random mix of requests
    for (int n = 0; n < 24; n++) begin
      logic [7:0] cmd;
      logic [7:0] go;
      case ($urandom % 4)
        0, 3:    cmd = 8'hB4;
        1:       cmd = 8'hB5;
        default: cmd = 8'($urandom);
      endcase
      go = (($urandom % 5) == 0) ? 8'($urandom) : 8'h96;
      run_case("R9 random request", cmd, go);
    end

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule